// File: doc/BRIEF.md
# Secondary Interrupt Controller with Passthrough

This block collects 32 level-sensitive interrupt sources and puts them in front of a primary interrupt controller. It samples each source into a raw-level register, gates the raw levels with a software-controlled enable mask, and drives the OR of all enabled sources on one dedicated output line (line 31). A fixed window of lines, 21 through 30, can also be routed around the mask. When a line's passthrough bit is set, its output copies that line's raw level, so the primary controller sees it as an individual source.

Software reaches the block through a simple 32-bit register bus with byte addresses. The register is selected by the address shifted right by two, within a 4 KB window. The enable mask and the passthrough register each have separate set and clear words, so software never needs a read-modify-write. A software-interrupt alias works on bit 0 of the mask. Read data is registered and appears one cycle after the request.

Top module: `sec_irq_ctrl`

## Requirements
- R1: After reset the raw level, the enable mask and the passthrough register are all zero, every `irq_o` line is low and `bus_rdata_o` is zero.
- R2: Raw-level bit i copies `irq_i[i]` one clock after it is sampled. Reading word 1 (byte offset 0x04) returns the raw levels.
- R3: A write to word 2 (0x08) ORs the write data into the enable mask. A write to word 3 (0x0C) clears each mask bit where the data holds a one. Reading word 2 returns the mask.
- R4: Reading word 0 (0x00) returns raw AND mask. `irq_o[31]` is high exactly when that value is nonzero.
- R5: Reading word 4 (0x10) returns raw bit 0 in bit 0, with zeros above. A nonzero write to word 4 sets mask bit 0 and a nonzero write to word 5 (0x14) clears it. A zero write to either has no effect.
- R6: A write to word 8 (0x20) ORs the data ANDed with 0x7FE00000 into the passthrough register, so only bits 21 to 30 can be set. Reading word 8 returns that register.
- R7: A write to word 9 (0x24) clears each passthrough bit where the data holds a one.
- R8: For each line i from 21 to 30, `irq_o[i]` equals raw bit i while passthrough bit i is set and is low while it is clear. It follows later raw changes and takes the current raw level right after any passthrough write. Lines 0 to 20 are always low.
- R9: A read of any word other than 0, 1, 2, 4 or 8 returns zero. A write to any word other than 2, 3, 4, 5, 8 or 9 changes neither the mask nor the passthrough register.
- R10: `bus_rdata_o` takes the value of a read request at the clock edge that samples it and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 32 | Level-sensitive interrupt sources |
| bus_valid_i | input | 1 | Bus request valid for this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address within the 4 KB window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 32 | Line 31 combined, lines 21 to 30 passthrough, others low |

## Verification
Every stored bit reaches the ports combinationally from its register. A wrong mask bit therefore shows on `irq_o[31]` in the same cycle as soon as the matching raw bit is high. A wrong passthrough bit shows on its own line as soon as that input is high. The bench reads each state back through the bus, where it appears one clock after the request. It also drives input patterns that make a corrupted mask or window bit change an output line at once. Decode faults show at the ports as a wrong word on a read, or as a write landing in the wrong register, and the next read-back exposes them.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned WORD_W = ADDR_W - 2;

  typedef enum logic [WORD_W-1:0] {
    W_STATUS   = 10'd0,
    W_RAW      = 10'd1,
    W_EN       = 10'd2,
    W_EN_CLR   = 10'd3,
    W_SOFT     = 10'd4,
    W_SOFT_CLR = 10'd5,
    W_PT       = 10'd8,
    W_PT_CLR   = 10'd9
  } word_e;

  function automatic logic [DATA_W-1:0] range_mask(int unsigned lo, int unsigned hi);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int unsigned b = 0; b < DATA_W; b++)
      if (b >= lo && b <= hi) m[b] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/sic_level_reg.sv
module sic_level_reg #(
  parameter int unsigned N = sic_pkg::DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  output logic [N-1:0] raw_o
);
  logic [N-1:0] raw_q;
  logic         seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      raw_q  <= irq_i;
      seen_q <= 1'b1;
    end
  end

  assign raw_o = raw_q;

  a_r2_raw_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (raw_q == $past(irq_i)));
endmodule

// File: rtl/sic_regfile.sv
module sic_regfile
  import sic_pkg::*;
#(
  parameter int unsigned PT_LO = 21,
  parameter int unsigned PT_HI = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic [DATA_W-1:0] raw_i,
  output logic [DATA_W-1:0] en_o,
  output logic [DATA_W-1:0] pt_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [DATA_W-1:0] WIN = range_mask(PT_LO, PT_HI);

  logic [WORD_W-1:0] word;
  logic              wr_req, rd_req, nz;
  logic              unused_addr_lsb;
  logic [DATA_W-1:0] en_q, en_d, pt_q, pt_d, rd_val, rdata_q;
  logic              wr_known, rd_known;

  assign word            = bus_addr_i[ADDR_W-1:2];
  assign unused_addr_lsb = ^bus_addr_i[1:0];
  assign wr_req          = bus_valid_i & bus_write_i;
  assign rd_req          = bus_valid_i & ~bus_write_i;
  assign nz              = |bus_wdata_i;

  always_comb begin
    en_d     = en_q;
    pt_d     = pt_q;
    wr_known = 1'b1;
    case (word)
      W_EN:       en_d = en_q | bus_wdata_i;
      W_EN_CLR:   en_d = en_q & ~bus_wdata_i;
      W_SOFT:     en_d = {en_q[DATA_W-1:1], en_q[0] | nz};
      W_SOFT_CLR: en_d = {en_q[DATA_W-1:1], en_q[0] & ~nz};
      W_PT:       pt_d = pt_q | (bus_wdata_i & WIN);
      W_PT_CLR:   pt_d = pt_q & ~bus_wdata_i;
      default:    wr_known = 1'b0;
    endcase
  end

  always_comb begin
    rd_known = 1'b1;
    case (word)
      W_STATUS: rd_val = raw_i & en_q;
      W_RAW:    rd_val = raw_i;
      W_EN:     rd_val = en_q;
      W_SOFT:   rd_val = {{(DATA_W-1){1'b0}}, raw_i[0]};
      W_PT:     rd_val = pt_q;
      default: begin
        rd_val   = '0;
        rd_known = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      pt_q    <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_req) begin
        en_q <= en_d;
        pt_q <= pt_d;
      end
      if (rd_req) rdata_q <= rd_val;
    end
  end

  assign en_o    = en_q;
  assign pt_o    = pt_q;
  assign rdata_o = rdata_q;

  a_r3_en_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && word == W_EN) |=> ((en_q & $past(bus_wdata_i)) == $past(bus_wdata_i)));
  a_r3_en_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && word == W_EN_CLR) |=> ((en_q & $past(bus_wdata_i)) == '0));
  a_r5_soft_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && word == W_SOFT_CLR && nz) |=> !en_q[0]);
  a_r6_pt_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && word == W_PT) |=> (pt_q == ($past(pt_q) | ($past(bus_wdata_i) & WIN))));
  a_r7_pt_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && word == W_PT_CLR) |=> ((pt_q & $past(bus_wdata_i)) == '0));
  a_r9_undef_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && !wr_known) |=> ($stable(en_q) && $stable(pt_q)));
  a_r9_undef_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && !rd_known) |=> (rdata_q == '0));
  a_r10_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> $stable(rdata_q));
endmodule

// File: rtl/sic_out_map.sv
module sic_out_map
  import sic_pkg::*;
#(
  parameter int unsigned PT_LO    = 21,
  parameter int unsigned PT_HI    = 30,
  parameter int unsigned COMB_IDX = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] raw_i,
  input  logic [DATA_W-1:0] en_i,
  input  logic [DATA_W-1:0] pt_i,
  output logic [DATA_W-1:0] irq_o
);
  localparam logic [DATA_W-1:0] WIN = range_mask(PT_LO, PT_HI);

  logic unused_pt;
  assign unused_pt = ^(pt_i & ~WIN);

  for (genvar i = 0; i < DATA_W; i++) begin : g_line
    if (i == COMB_IDX) begin : g_comb
      assign irq_o[i] = |(raw_i & en_i);
    end else if (i >= PT_LO && i <= PT_HI) begin : g_pt
      assign irq_o[i] = pt_i[i] & raw_i[i];
    end else begin : g_off
      assign irq_o[i] = 1'b0;
    end
  end

  a_r8_quiet_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o & ~WIN & ~(DATA_W'(1) << COMB_IDX)) == '0));
  a_r8_pt_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o & WIN & ~pt_i) == '0));
endmodule

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl
  import sic_pkg::*;
#(
  parameter int unsigned PT_LO    = 21,
  parameter int unsigned PT_HI    = 30,
  parameter int unsigned COMB_IDX = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] irq_i,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [DATA_W-1:0] irq_o
);
  logic [DATA_W-1:0] raw, en, pt;

  sic_level_reg #(.N(DATA_W)) u_level (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .irq_i (irq_i),
    .raw_o (raw)
  );

  sic_regfile #(.PT_LO(PT_LO), .PT_HI(PT_HI)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_valid_i(bus_valid_i),
    .bus_write_i(bus_write_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .raw_i      (raw),
    .en_o       (en),
    .pt_o       (pt),
    .rdata_o    (bus_rdata_o)
  );

  sic_out_map #(.PT_LO(PT_LO), .PT_HI(PT_HI), .COMB_IDX(COMB_IDX)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i (raw),
    .en_i  (en),
    .pt_i  (pt),
    .irq_o (irq_o)
  );

  a_r4_comb_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o[COMB_IDX]) |-> ((raw & en) != '0));
endmodule

// File: tb/tb_sec_irq_ctrl.sv
module tb_sec_irq_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WDOG       = 5000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] irq_i = '0;
  logic        bus_valid_i = 1'b0;
  logic        bus_write_i = 1'b0;
  logic [11:0] bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq_i),
    .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(int word, logic [31:0] d);
    @(negedge clk);
    bus_valid_i = 1'b1; bus_write_i = 1'b1;
    bus_addr_i = 12'(word * 4); bus_wdata_i = d;
    @(negedge clk);
    bus_valid_i = 1'b0; bus_write_i = 1'b0;
  endtask

  task automatic rd(int word, output logic [31:0] d);
    @(negedge clk);
    bus_valid_i = 1'b1; bus_write_i = 1'b0; bus_addr_i = 12'(word * 4);
    @(negedge clk);
    d = bus_rdata_o;
    bus_valid_i = 1'b0;
  endtask

  task automatic drive_irq(logic [31:0] v);
    @(negedge clk);
    irq_i = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq_o after reset", irq_o, 32'h0);
    chk("R1 rdata after reset", bus_rdata_o, 32'h0);
    rd(0, d); chk("R1 status", d, 32'h0);
    rd(2, d); chk("R1 mask", d, 32'h0);
    rd(8, d); chk("R1 passthrough", d, 32'h0);
  endtask

  task automatic t_raw();
    logic [31:0] d;
    drive_irq(32'hA5A5_0F0F);
    rd(1, d); chk("R2 raw pattern A", d, 32'hA5A5_0F0F);
    drive_irq(32'h1234_5678);
    rd(1, d); chk("R2 raw pattern B", d, 32'h1234_5678);
    chk("R8 low lines idle", irq_o, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    drive_irq(32'hA5A5_0F0F);
    wr(2, 32'h0000_00F0);
    rd(2, d); chk("R3 set", d, 32'h0000_00F0);
    chk("R4 comb low when no overlap", irq_o, 32'h0);
    wr(2, 32'h0000_0F00);
    rd(2, d); chk("R3 set ors", d, 32'h0000_0FF0);
    wr(3, 32'h0000_00F0);
    rd(2, d); chk("R3 clear", d, 32'h0000_0F00);
    rd(0, d); chk("R4 status", d, 32'h0000_0F00);
    chk("R4 comb high", irq_o, 32'h8000_0000);
    wr(3, 32'hFFFF_FFFF);
    chk("R4 comb low after clear", irq_o, 32'h0);
  endtask

  task automatic t_soft();
    logic [31:0] d;
    drive_irq(32'h0000_0003);
    rd(4, d); chk("R5 soft read", d, 32'h1);
    wr(4, 32'h0);
    rd(2, d); chk("R5 zero set ignored", d, 32'h0);
    wr(4, 32'h0000_0500);
    rd(2, d); chk("R5 nonzero set", d, 32'h1);
    chk("R4 comb via soft bit", irq_o, 32'h8000_0000);
    wr(5, 32'h0);
    rd(2, d); chk("R5 zero clear ignored", d, 32'h1);
    wr(5, 32'h8000_0000);
    rd(2, d); chk("R5 nonzero clear", d, 32'h0);
    chk("R4 comb low after soft clear", irq_o, 32'h0);
    drive_irq(32'h0000_0002);
    rd(4, d); chk("R5 soft read zero", d, 32'h0);
  endtask

  task automatic t_passthrough();
    logic [31:0] d;
    drive_irq(32'hAAAA_AAAA);
    chk("R8 no passthrough yet", irq_o, 32'h0);
    wr(8, 32'hFFFF_FFFF);
    rd(8, d); chk("R6 window mask", d, 32'h7FE0_0000);
    chk("R8 refresh on write", irq_o, 32'h2AA0_0000);
    drive_irq(32'h5555_5555);
    chk("R8 follows raw", irq_o, 32'h5540_0000);
    wr(9, 32'h0FE0_0000);
    rd(8, d); chk("R7 clear", d, 32'h7000_0000);
    chk("R8 cleared lines low", irq_o, 32'h5000_0000);
    wr(2, 32'h0000_0001);
    chk("R4 comb with passthrough", irq_o, 32'hD000_0000);
    wr(9, 32'hFFFF_FFFF);
    wr(3, 32'hFFFF_FFFF);
    chk("R7 all clear", irq_o, 32'h0);
  endtask

  task automatic t_undef();
    logic [31:0] d;
    drive_irq(32'hFFFF_FFFF);
    wr(2, 32'h0000_0010);
    wr(8, 32'h0020_0000);
    rd(6, d);     chk("R9 read word 6", d, 32'h0);
    rd(7, d);     chk("R9 read word 7", d, 32'h0);
    rd(10, d);    chk("R9 read word 10", d, 32'h0);
    rd(1023, d);  chk("R9 read top word", d, 32'h0);
    wr(6, 32'hFFFF_FFFF);
    wr(10, 32'hFFFF_FFFF);
    wr(1023, 32'hFFFF_FFFF);
    wr(1, 32'hFFFF_FFFF);
    rd(2, d); chk("R9 mask untouched", d, 32'h0000_0010);
    rd(8, d); chk("R9 passthrough untouched", d, 32'h0020_0000);
    chk("R9 outputs untouched", irq_o, 32'h8020_0000);
  endtask

  task automatic t_rd_timing();
    logic [31:0] d;
    drive_irq(32'h0F0F_0001);
    rd(1, d); chk("R10 first read", d, 32'h0F0F_0001);
    @(negedge clk);
    bus_valid_i = 1'b1; bus_write_i = 1'b0; bus_addr_i = 12'h020;
    #1 chk("R10 old data before edge", bus_rdata_o, 32'h0F0F_0001);
    @(negedge clk);
    bus_valid_i = 1'b0;
    chk("R10 new data after edge", bus_rdata_o, 32'h0020_0000);
    repeat (2) @(negedge clk);
    chk("R10 data held", bus_rdata_o, 32'h0020_0000);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_raw();
    t_mask();
    t_soft();
    t_passthrough();
    t_undef();
    t_rd_timing();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule